// File: doc/BRIEF.md
# Indexed Block-Transfer Configuration Target

This block is a two-wire serial target that holds a bank of fifteen byte-wide configuration registers. A host reaches them with a framed block protocol. A write carries the device address, then a starting register index, then a byte count, then the data bytes. A read first sets the index with a short write. It then issues a repeated start and the read address. The target answers with a count byte and then streams register contents from the stored index onward.

SCL and SDA enter through two-stage synchronizers and are edge-detected on the system clock. SDA is driven open-drain: `sda_oe` high means the pin is pulled low. All fifteen registers are presented at once on a flat parallel bus to the surrounding logic. Strap levels and a revision code are mirrored into read-only bit fields. Data moves only on the serial pins, so the parallel side needs no handshake: it is a level bus that changes when a byte is written.

Top module: `i2c_idx_target`

## Requirements
- R1: Start is SDA falling while SCL is high. Stop is SDA rising while SCL is high. After a stop the target is idle with SDA released and acknowledges nothing until the next start. A repeated start returns to the address phase and keeps the stored index.
- R2: The address byte 0xD2 (write) and 0xD3 (read) is acknowledged. Any other address byte is not acknowledged, and after it the target acknowledges no further byte until a new start.
- R3: In a write, the index byte and the count byte are acknowledged. Data byte k (counting from 0) of an accepted write lands in register N+k, after index wrapping.
- R4: Only as many data bytes as the count byte allows are acknowledged and stored. Later bytes are not acknowledged and change nothing. A count of 0 stores no byte.
- R5: After the read address is acknowledged, the target first sends the value of register 7, then registers N, N+1, … MSB first, one per host acknowledge.
- R6: When the host does not acknowledge a read byte, the target releases SDA. It drives nothing (the host reads 0xFF) until the next start, and a new transaction then works normally.
- R7: After register 14 the index wraps to 0, for both reads and writes. An index of 15 or above reads as 0x00, drops written data, and is followed by index 0.
- R8: Reset values: reg0 0x00, reg2 0xFF, reg3 0x37, reg5 0x00, reg6 0x00, reg7 0x0F, reg9 0x10, reg10 0x1F, reg11–reg14 0x00. The writable bits of reg1 reset to 1.
- R9: Read-only fields: reg1[7:3] equals `strap_fs`, reg4[7] equals `strap_mult`, and reg8 equals {`rev_id`, 4'b0001}. Writes leave read-only and reserved bits unchanged. Reserved bits read 0: reg1 keeps [2:0] writable, reg3 bit 3, reg4[6:0], reg5[7:3], reg6, reg10 bit 5 and reg14[7:5].
- R10: `cfg_regs[8*i+7 : 8*i]` shows register i. A written byte appears there no later than the acknowledge clock of that byte.
- R11: The target changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| sda_oe | output | 1 | Pull SDA low when high |
| strap_fs | input | 5 | Latched strap levels mirrored into reg1[7:3] |
| strap_mult | input | 1 | Latched strap level mirrored into reg4[7] |
| rev_id | input | 4 | Revision code shown in reg8[7:4] |
| cfg_regs | output | 120 | All fifteen registers, register i at bits 8*i+7..8*i |

## Verification
The hardest states to reach are the ones in which the target must stay silent mid-frame. These are a data byte past the count, bytes clocked after a rejected address, and a read that the host has already refused. From the pins each looks the same as an acknowledged byte. The bench therefore drives complete frames that continue past those points. It counts the ninth-clock acknowledges, reads back 0xFF from the released bus, and then opens a fresh transaction to show that the target recovered. Wrapping is reached by starting frames at index 14 and at an index beyond the bank.

// File: rtl/i2cblk_pkg.sv
package i2cblk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_HACK, ST_TXLOAD
  } eng_state_t;

  typedef enum logic [1:0] {
    FLD_ADDR, FLD_INDEX, FLD_COUNT, FLD_DATA
  } field_t;

  // writable bits per register index
  function automatic logic [7:0] reg_wmask(int unsigned i);
    case (i)
      1:       return 8'h07;
      3:       return 8'hF7;
      4, 6, 8: return 8'h00;
      5:       return 8'h07;
      10:      return 8'hDF;
      14:      return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reg_rstval(int unsigned i);
    case (i)
      1:       return 8'h07;
      2:       return 8'hFF;
      3:       return 8'h37;
      7:       return 8'h0F;
      9:       return 8'h10;
      10:      return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC-2:0], sda_i};
      scl_prev <= scl_pipe[SYNC-1];
      sda_prev <= sda_pipe[SYNC-1];
    end
  end

  assign scl_lvl   = scl_pipe[SYNC-1];
  assign sda_lvl   = sda_pipe[SYNC-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_idx_engine.sv
module i2c_idx_engine
  import i2cblk_pkg::*;
#(
  parameter int unsigned NREG     = 15,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] count_val,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       bus_idle,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx
);
  localparam logic [7:0] LAST_IDX = 8'(NREG - 1);

  eng_state_t state;
  field_t     field;
  logic [2:0] bitcnt;
  logic [6:0] shreg;
  logic [7:0] txsh, txbyte, idx_q, left_q;
  logic       ack_q, ack_go, tx_next, oe_q;
  logic [7:0] rx_byte;

  function automatic logic [7:0] next_idx(logic [7:0] i);
    return (i >= LAST_IDX) ? 8'd0 : i + 8'd1;
  endfunction

  assign rx_byte  = {shreg, sda_lvl};
  assign sda_oe   = oe_q;
  assign bus_idle = (state == ST_IDLE);
  assign rd_idx   = idx_q;
  assign wr_idx   = idx_q;
  assign wr_data  = rx_byte;
  assign wr_en    = (state == ST_RX) && scl_rise && (bitcnt == 3'd7) &&
                    (field == FLD_DATA) && (left_q != 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      field   <= FLD_ADDR;
      bitcnt  <= '0;
      shreg   <= '0;
      txsh    <= '0;
      txbyte  <= '0;
      idx_q   <= '0;
      left_q  <= '0;
      ack_q   <= 1'b0;
      ack_go  <= 1'b0;
      tx_next <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_RX;
      field  <= FLD_ADDR;
      bitcnt <= '0;
      oe_q   <= 1'b0;
    end else if (stop_evt) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else begin
      case (state)
        ST_RX: if (scl_rise) begin
          shreg  <= rx_byte[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            state   <= ST_ACK;
            ack_go  <= 1'b0;
            ack_q   <= 1'b0;
            tx_next <= 1'b0;
            case (field)
              FLD_ADDR: if (rx_byte[7:1] == DEV_ADDR) begin
                ack_q <= 1'b1;
                if (rx_byte[0]) begin
                  tx_next <= 1'b1;
                  txbyte  <= count_val;
                end else begin
                  field <= FLD_INDEX;
                end
              end
              FLD_INDEX: begin
                ack_q <= 1'b1;
                idx_q <= rx_byte;
                field <= FLD_COUNT;
              end
              FLD_COUNT: begin
                ack_q  <= 1'b1;
                left_q <= rx_byte;
                field  <= FLD_DATA;
              end
              default: if (left_q != 8'd0) begin
                ack_q  <= 1'b1;
                left_q <= left_q - 8'd1;
                idx_q  <= next_idx(idx_q);
              end
            endcase
          end
        end
        ST_ACK: if (scl_fall) begin
          if (!ack_go) begin
            oe_q   <= ack_q;
            ack_go <= 1'b1;
          end else if (!ack_q) begin
            oe_q  <= 1'b0;
            state <= ST_IDLE;
          end else if (tx_next) begin
            oe_q   <= ~txbyte[7];
            txsh   <= {txbyte[6:0], 1'b0};
            bitcnt <= '0;
            state  <= ST_TX;
          end else begin
            oe_q   <= 1'b0;
            bitcnt <= '0;
            state  <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 3'd1;
            ack_go <= 1'b0;
            if (bitcnt == 3'd7) state <= ST_HACK;
          end else if (scl_fall) begin
            oe_q <= ~txsh[7];
            txsh <= {txsh[6:0], 1'b0};
          end
        end
        ST_HACK: begin
          if (scl_fall && !ack_go) begin
            oe_q   <= 1'b0;
            ack_go <= 1'b1;
          end else if (scl_rise && ack_go) begin
            if (sda_lvl) begin
              state <= ST_IDLE;
            end else begin
              txbyte <= rd_data;
              idx_q  <= next_idx(idx_q);
              state  <= ST_TXLOAD;
            end
          end
        end
        ST_TXLOAD: if (scl_fall) begin
          oe_q   <= ~txbyte[7];
          txsh   <= {txbyte[6:0], 1'b0};
          bitcnt <= '0;
          state  <= ST_TX;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import i2cblk_pkg::*;
#(
  parameter int unsigned NREG   = 15,
  parameter logic [3:0]  VENDOR = 4'h1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [7:0]      rd_idx,
  input  logic [4:0]      strap_fs,
  input  logic            strap_mult,
  input  logic [3:0]      rev_id,
  output logic [7:0]      rd_data,
  output logic [7:0]      count_val,
  output logic [NREG*8-1:0] cfg_regs
);
  localparam int unsigned IW      = $clog2(NREG);
  localparam int unsigned CNT_IDX = 7;

  logic [7:0] view [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] M = reg_wmask(i);
    logic [7:0] store;
    logic [7:0] ro_bits;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        store <= reg_rstval(i) & M;
      else if (wr_en && wr_idx == 8'(i))
        store <= (store & ~M) | (wr_data & M);
    end

    if (i == 1) begin : g_fs
      assign ro_bits = {strap_fs, 3'b000};
    end else if (i == 4) begin : g_ms
      assign ro_bits = {strap_mult, 7'b0};
    end else if (i == 8) begin : g_id
      assign ro_bits = {rev_id, VENDOR};
    end else begin : g_none
      assign ro_bits = 8'h00;
    end

    assign view[i]         = store | ro_bits;
    assign cfg_regs[8*i +: 8] = view[i];
  end

  assign rd_data   = (rd_idx < 8'(NREG)) ? view[rd_idx[IW-1:0]] : 8'h00;
  assign count_val = view[CNT_IDX];
endmodule

// File: rtl/i2c_idx_target.sv
module i2c_idx_target #(
  parameter int unsigned NREG     = 15,
  parameter int unsigned SYNC     = 2,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter logic [3:0]  VENDOR   = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [4:0]        strap_fs,
  input  logic              strap_mult,
  input  logic [3:0]        rev_id,
  output logic [NREG*8-1:0] cfg_regs
);
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic       bus_idle, reg_wr;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, count_val;

  i2c_line_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_idx_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .count_val(count_val), .rd_data(rd_data), .sda_oe(sda_oe),
    .bus_idle(bus_idle), .wr_en(reg_wr), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx)
  );

  cfg_regfile #(.NREG(NREG), .VENDOR(VENDOR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .strap_fs(strap_fs),
    .strap_mult(strap_mult), .rev_id(rev_id), .rd_data(rd_data),
    .count_val(count_val), .cfg_regs(cfg_regs)
  );
endmodule

// File: rtl/i2c_idx_target_chk.sv
module i2c_idx_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_oe,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       bus_idle,
  input logic       reg_wr,
  input logic [7:0] wr_idx,
  input logic [7:0] wr_data,
  input logic [7:0] cfg_reg0
);
  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_lvl));

  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe);

  a_r6_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && !start_evt) |=> bus_idle);

  a_r10_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wr_idx == 8'd0) |=> (cfg_reg0 == $past(wr_data)));
endmodule

bind i2c_idx_target i2c_idx_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .bus_idle(bus_idle),
  .reg_wr(reg_wr), .wr_idx(wr_idx), .wr_data(wr_data),
  .cfg_reg0(cfg_regs[7:0])
);

// File: tb/tb_i2c_idx_target.sv
`timescale 1ns/1ps
module tb_i2c_idx_target;
  localparam int Q = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic host_scl = 1'b1, host_pull = 1'b0;
  logic sda_oe, sda_line;
  logic [4:0] strap_fs = 5'b10110;
  logic strap_mult = 1'b1;
  logic [3:0] rev_id = 4'hA;
  logic [119:0] cfg;

  assign sda_line = ~(sda_oe | host_pull);

  i2c_idx_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_fs(strap_fs), .strap_mult(strap_mult),
    .rev_id(rev_id), .cfg_regs(cfg)
  );

  int n_chk = 0, n_fail = 0, r11_bad = 0;
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];
  logic [7:0] rcount;
  logic [15:0] ackv;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(int i);
    return cfg[8*i +: 8];
  endfunction

  task automatic bit_out(input logic b);
    host_pull = ~b;
    #Q host_scl = 1'b1;
    #(2*Q) host_scl = 1'b0;
    #Q;
  endtask

  task automatic bit_in(output logic b);
    logic s0, s1;
    host_pull = 1'b0;
    #Q host_scl = 1'b1;
    #(Q/2) s0 = sda_line;
    #Q s1 = sda_line;
    #(Q/2) host_scl = 1'b0;
    #Q;
    if (s0 !== s1) r11_bad++;
    b = s0;
  endtask

  task automatic byte_out(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic byte_in(output logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(~ack);
  endtask

  task automatic i2c_start();
    host_pull = 1'b0;
    #Q host_scl = 1'b1;
    #Q host_pull = 1'b1;
    #Q host_scl = 1'b0;
    #Q;
  endtask

  task automatic i2c_stop();
    host_pull = 1'b1;
    #Q host_scl = 1'b1;
    #Q host_pull = 1'b0;
    #Q;
  endtask

  task automatic wr_txn(input logic [7:0] n, input logic [7:0] cnt, input int nb);
    logic a;
    ackv = '0;
    i2c_start();
    byte_out(8'hD2, a); ackv[0] = a;
    byte_out(n, a);     ackv[1] = a;
    byte_out(cnt, a);   ackv[2] = a;
    for (int k = 0; k < nb; k++) begin
      byte_out(wbuf[k], a);
      ackv[3+k] = a;
    end
    i2c_stop();
  endtask

  task automatic rd_txn(input logic [7:0] n, input int nb);
    logic a;
    ackv = '0;
    i2c_start();
    byte_out(8'hD2, a); ackv[0] = a;
    byte_out(n, a);     ackv[1] = a;
    i2c_start();
    byte_out(8'hD3, a); ackv[2] = a;
    byte_in(rcount, 1'b1);
    for (int k = 0; k < nb; k++) byte_in(rbuf[k], k != nb - 1);
    i2c_stop();
  endtask

  task automatic t_reset();
    check("R8 reg0", rg(0), 8'h00);
    check("R8 reg2", rg(2), 8'hFF);
    check("R8 reg3", rg(3), 8'h37);
    check("R8 reg7", rg(7), 8'h0F);
    check("R8 reg9", rg(9), 8'h10);
    check("R8 reg10", rg(10), 8'h1F);
    check("R8 reg14", rg(14), 8'h00);
    check("R9 reg1 strap+default", rg(1), 8'hB7);
    check("R9 reg4 strap", rg(4), 8'h80);
    check("R9 reg8 id", rg(8), 8'hA1);
    check("R1 idle sda released", sda_oe, 1'b0);
  endtask

  task automatic t_write_basic();
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
    wr_txn(8'd11, 8'd3, 3);
    check("R3 acks", ackv[5:0], 6'b111111);
    check("R10 reg11", rg(11), 8'hA5);
    check("R3 reg12", rg(12), 8'h5A);
    check("R3 reg13", rg(13), 8'hC3);
  endtask

  task automatic t_read();
    r11_bad = 0;
    rd_txn(8'd11, 3);
    check("R5 addr acks", ackv[2:0], 3'b111);
    check("R5 count byte", rcount, 8'h0F);
    check("R5 byte0", rbuf[0], 8'hA5);
    check("R5 byte1", rbuf[1], 8'h5A);
    check("R5 byte2", rbuf[2], 8'hC3);
    check("R11 sda stable while scl high", r11_bad, 0);
    wbuf[0] = 8'h05;
    wr_txn(8'd7, 8'd1, 1);
    rd_txn(8'd12, 1);
    check("R5 count from reg7", rcount, 8'h05);
    check("R5 byte after new count", rbuf[0], 8'h5A);
  endtask

  task automatic t_count_limit();
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    wr_txn(8'd0, 8'd1, 2);
    check("R4 acks past count", ackv[4:0], 5'b01111);
    check("R4 reg0 stored", rg(0), 8'h12);
    check("R4 reg1 untouched", rg(1), 8'hB7);
    wbuf[0] = 8'h55;
    wr_txn(8'd9, 8'd0, 1);
    check("R4 zero count nack", ackv[3:0], 4'b0111);
    check("R4 zero count reg9", rg(9), 8'h10);
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'hFF; wbuf[1] = 8'h99;
    wr_txn(8'd14, 8'd2, 2);
    check("R9 reg14 reserved bits", rg(14), 8'h1F);
    check("R7 write wraps to reg0", rg(0), 8'h99);
    rd_txn(8'd14, 2);
    check("R7 read reg14", rbuf[0], 8'h1F);
    check("R7 read wraps reg0", rbuf[1], 8'h99);
  endtask

  task automatic t_ro();
    wbuf[0] = 8'h00;
    wr_txn(8'd1, 8'd1, 1);
    check("R9 reg1 ro kept", rg(1), 8'hB0);
    wbuf[0] = 8'hFF;
    wr_txn(8'd4, 8'd1, 1);
    check("R9 reg4 reserved", rg(4), 8'h80);
    wbuf[0] = 8'h00;
    wr_txn(8'd8, 8'd1, 1);
    check("R9 reg8 id kept", rg(8), 8'hA1);
    rd_txn(8'd8, 1);
    check("R9 id via bus", rbuf[0], 8'hA1);
  endtask

  task automatic t_outrange();
    wbuf[0] = 8'h77; wbuf[1] = 8'h66;
    wr_txn(8'd20, 8'd2, 2);
    check("R7 out-of-range acks", ackv[4:0], 5'b11111);
    check("R7 out-of-range then reg0", rg(0), 8'h66);
    rd_txn(8'd20, 2);
    check("R7 out-of-range reads zero", rbuf[0], 8'h00);
    check("R7 next is reg0", rbuf[1], 8'h66);
  endtask

  task automatic t_badaddr();
    logic a;
    i2c_start();
    byte_out(8'hA0, a);
    check("R2 foreign address nack", a, 1'b0);
    byte_out(8'hD2, a);
    check("R2 ignored until start", a, 1'b0);
    i2c_stop();
    i2c_start();
    byte_out(8'hD2, a);
    check("R2 write address ack", a, 1'b1);
    i2c_stop();
  endtask

  task automatic t_host_nack();
    logic a;
    logic [7:0] v;
    i2c_start();
    byte_out(8'hD2, a);
    byte_out(8'd2, a);
    i2c_start();
    byte_out(8'hD3, a);
    byte_in(v, 1'b0);
    byte_in(v, 1'b0);
    check("R6 silent after host nack", v, 8'hFF);
    i2c_stop();
    rd_txn(8'd2, 1);
    check("R6 recovers count", rcount, 8'h05);
    check("R6 recovers data", rbuf[0], 8'hFF);
  endtask

  task automatic t_stop_mid();
    logic a;
    wbuf[0] = 8'h11;
    wr_txn(8'd2, 8'd2, 1);
    check("R1 stop mid write reg2", rg(2), 8'h11);
    check("R1 stop mid write reg3", rg(3), 8'h37);
    byte_out(8'hD2, a);
    check("R1 idle after stop", a, 1'b0);
    i2c_stop();
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(1_800_000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    #23 rst_n = 1'b1;
    #100;
    t_reset();
    t_write_basic();
    t_read();
    t_count_limit();
    t_wrap();
    t_ro();
    t_outrange();
    t_badaddr();
    t_host_nack();
    t_stop_mid();
    #200;
    report();
  end
endmodule